// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block keeps a small table of interrupt messages, one entry per vector, and decides for each interrupt request whether to send the stored message at once or hold it as pending. Software programs the table through a 32-bit word-addressed register port and reads the pending bits through the same port. The device side raises requests one vector number at a time and says which vectors it has in use. Two plain control inputs, a global enable and a function-wide mask, come from the capability logic that owns them.

Each vector is blocked either by its own mask bit or by the function-wide mask. The function-wide mask is in force when the enable input is low or the mask-all input is high. A request on a blocked vector sets its pending bit. Whenever a vector goes from blocked to open, for any reason, a set pending bit is cleared and the message is queued. Queued messages leave on a valid/ready stream, lowest vector number first. The block drives `msg_valid` and holds the vector, address and data steady until the cycle in which `msg_ready` is high. A request on a vector that is already queued and not yet loaded adds no second message.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset every table word reads 0 except each vector-control word, which reads 1 (masked), all pending bits read 0 and `msg_valid` is low.
- R2: Entry v occupies word addresses 4v to 4v+3: address bits 31:0, address bits 63:32, data, and vector control with the mask in bit 0 (other bits read 0). A read returns `reg_rdata` with `reg_rvalid` high one cycle after `reg_rd`. A 64-bit access is two word accesses.
- R3: A vector is blocked when its mask bit is 1, `msix_en` is 0, or `mask_all` is 1.
- R4: A request on an open, in-use vector below NUM_VEC raises `msg_valid` two cycles later, carrying that vector, its 64-bit address {high word, low word} and its data word.
- R5: A request on a blocked, in-use vector sends nothing and sets its pending bit.
- R6: A request with `req_vec` at or above NUM_VEC, or on a vector whose `vec_used` bit is 0, sends nothing and sets no pending bit.
- R7: When a write to a vector-control word opens a pending vector, its pending bit clears and its message is sent.
- R8: When `msix_en` or `mask_all` opens the function, every pending vector whose own mask is 0 is sent. A pending vector whose own mask is 1 stays pending.
- R9: With `reg_pba` high, word w returns pending bit v at bit position v mod 32 of word v/32. There are 2*ceil(NUM_VEC/64) such words, any word beyond them reads 0, and writes to this region change nothing.
- R10: When a vector's `vec_used` bit falls, its pending bit clears and no message is sent for it later.
- R11: Several queued messages leave one per handshake, lowest vector first. While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_vec`, `msg_addr` and `msg_data` hold their values.
- R12: Table word addresses at or above 4*NUM_VEC read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msix_en | input | 1 | Global enable of message interrupts |
| mask_all | input | 1 | Function-wide mask |
| vec_used | input | NUM_VEC | Per-vector in-use flags from the device |
| req_valid | input | 1 | Interrupt request strobe, one cycle per request |
| req_vec | input | VEC_W | Vector number of the request |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Outgoing message accepted |
| msg_vec | output | VEC_W | Vector of the outgoing message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_pba | input | 1 | 1 selects the pending-bit region, 0 the table |
| reg_waddr | input | WADDR_W | Word address within the selected region |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| reg_rvalid | output | 1 | Read data valid |

## Verification
The hardest case to reach is a replay burst: several vectors open in the same cycle while the output is stalled, and one pending vector must stay held by its own mask. The bench disables the function, raises requests on three open vectors and on one vector with its own mask set, then re-enables with `msg_ready` low. It watches the head message stay steady for several cycles, then drains the burst in ascending order and reads the pending region to confirm that only the masked vector is left.

// File: rtl/msix_pkg.sv
package msix_pkg;
  typedef struct packed {
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic [31:0] data;
    logic        mask;
  } vec_entry_t;

  // word slot inside a 16-byte table entry
  localparam logic [1:0] SLOT_ADDR_LO = 2'd0;
  localparam logic [1:0] SLOT_ADDR_HI = 2'd1;
  localparam logic [1:0] SLOT_DATA    = 2'd2;
  localparam logic [1:0] SLOT_CTRL    = 2'd3;
endpackage

// File: rtl/msix_entry_table.sv
module msix_entry_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 6,
  parameter int VEC_W   = 3,
  parameter int WADDR_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic               pba_sel,
  input  logic [WADDR_W-1:0] waddr,
  input  logic [31:0]        wdata,
  input  logic [NUM_VEC-1:0] pend,
  input  logic [VEC_W-1:0]   pick_vec,
  output logic [31:0]        rdata,
  output logic               rvalid,
  output logic [NUM_VEC-1:0] ctrl_mask,
  output logic [63:0]        pick_addr,
  output logic [31:0]        pick_data
);
  localparam int VSEL_W    = WADDR_W - 2;
  localparam int PBA_WORDS = ((NUM_VEC + 63) / 64) * 2;
  localparam int PBA_BITS  = PBA_WORDS * 32;

  vec_entry_t ent [NUM_VEC];

  logic [VSEL_W-1:0]   vsel;
  logic [1:0]          slot;
  logic [PBA_BITS-1:0] pba_flat;
  logic [31:0]         rd_word;

  assign vsel     = waddr[WADDR_W-1:2];
  assign slot     = waddr[1:0];
  assign pba_flat = {{(PBA_BITS-NUM_VEC){1'b0}}, pend};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        ent[v].addr_lo <= '0;
        ent[v].addr_hi <= '0;
        ent[v].data    <= '0;
        ent[v].mask    <= 1'b1;
      end
    end else if (wr && !pba_sel) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (vsel == VSEL_W'(v)) begin
          case (slot)
            SLOT_ADDR_LO: ent[v].addr_lo <= wdata;
            SLOT_ADDR_HI: ent[v].addr_hi <= wdata;
            SLOT_DATA:    ent[v].data    <= wdata;
            default:      ent[v].mask    <= wdata[0];
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (pba_sel) begin
      for (int w = 0; w < PBA_WORDS; w++) begin
        if (waddr == WADDR_W'(w)) rd_word = pba_flat[w*32 +: 32];
      end
    end else begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (vsel == VSEL_W'(v)) begin
          case (slot)
            SLOT_ADDR_LO: rd_word = ent[v].addr_lo;
            SLOT_ADDR_HI: rd_word = ent[v].addr_hi;
            SLOT_DATA:    rd_word = ent[v].data;
            default:      rd_word = {31'b0, ent[v].mask};
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_word;
    end
  end

  always_comb begin
    pick_addr = '0;
    pick_data = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (pick_vec == VEC_W'(v)) begin
        pick_addr = {ent[v].addr_hi, ent[v].addr_lo};
        pick_data = ent[v].data;
      end
    end
  end

  always_comb begin
    for (int v = 0; v < NUM_VEC; v++) ctrl_mask[v] = ent[v].mask;
  end
endmodule

// File: rtl/msix_pend_track.sv
module msix_pend_track #(
  parameter int NUM_VEC = 6,
  parameter int VEC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               func_mask,
  input  logic [NUM_VEC-1:0] ctrl_mask,
  input  logic [NUM_VEC-1:0] used,
  input  logic               req_valid,
  input  logic [VEC_W-1:0]   req_vec,
  input  logic [NUM_VEC-1:0] take,
  output logic [NUM_VEC-1:0] pend,
  output logic [NUM_VEC-1:0] due,
  output logic [NUM_VEC-1:0] eff_mask,
  output logic [NUM_VEC-1:0] mask_q
);
  logic [NUM_VEC-1:0] req_hit;
  logic [NUM_VEC-1:0] opened;
  logic [NUM_VEC-1:0] released;
  logic [NUM_VEC-1:0] used_q;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_hit
    // out-of-range vector numbers never match any slot
    assign req_hit[v] = req_valid && (req_vec == VEC_W'(v)) && used[v];
  end

  assign eff_mask = {NUM_VEC{func_mask}} | ctrl_mask;
  assign opened   = mask_q & ~eff_mask;
  assign released = used_q & ~used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      due    <= '0;
      mask_q <= '1;
      used_q <= '0;
    end else begin
      pend   <= (pend & ~opened & ~released) | (req_hit & eff_mask);
      due    <= (due & ~take) | (req_hit & ~eff_mask) | (opened & pend);
      mask_q <= eff_mask;
      used_q <= used;
    end
  end
endmodule

// File: rtl/msix_msg_arb.sv
module msix_msg_arb #(
  parameter int NUM_VEC = 6,
  parameter int VEC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] due,
  input  logic [63:0]        pick_addr,
  input  logic [31:0]        pick_data,
  input  logic               msg_ready,
  output logic [VEC_W-1:0]   pick_vec,
  output logic [NUM_VEC-1:0] take,
  output logic               msg_valid,
  output logic [VEC_W-1:0]   msg_vec,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  logic found;
  logic load;

  always_comb begin
    pick_vec = '0;
    found    = 1'b0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (due[v] && !found) begin
        pick_vec = VEC_W'(v);
        found    = 1'b1;
      end
    end
  end

  assign load = found && (!msg_valid || msg_ready);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_take
    assign take[v] = load && (pick_vec == VEC_W'(v));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_vec   <= '0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_vec   <= pick_vec;
      msg_addr  <= pick_addr;
      msg_data  <= pick_data;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl #(
  parameter int NUM_VEC = 6,
  parameter int VEC_W   = $clog2(NUM_VEC + 1),
  parameter int WADDR_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msix_en,
  input  logic               mask_all,
  input  logic [NUM_VEC-1:0] vec_used,
  input  logic               req_valid,
  input  logic [VEC_W-1:0]   req_vec,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [VEC_W-1:0]   msg_vec,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic               reg_pba,
  input  logic [WADDR_W-1:0] reg_waddr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               reg_rvalid
);
  logic               func_mask;
  logic [NUM_VEC-1:0] ctrl_mask;
  logic [NUM_VEC-1:0] pend_w;
  logic [NUM_VEC-1:0] due_w;
  logic [NUM_VEC-1:0] eff_mask_w;
  logic [NUM_VEC-1:0] mask_q_w;
  logic [NUM_VEC-1:0] take_w;
  logic [VEC_W-1:0]   pick_vec;
  logic [63:0]        pick_addr;
  logic [31:0]        pick_data;

  assign func_mask = !msix_en || mask_all;

  msix_entry_table #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .WADDR_W(WADDR_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr(reg_wr), .rd(reg_rd), .pba_sel(reg_pba), .waddr(reg_waddr), .wdata(reg_wdata),
    .pend(pend_w), .pick_vec(pick_vec),
    .rdata(reg_rdata), .rvalid(reg_rvalid), .ctrl_mask(ctrl_mask),
    .pick_addr(pick_addr), .pick_data(pick_data)
  );

  msix_pend_track #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .func_mask(func_mask), .ctrl_mask(ctrl_mask), .used(vec_used),
    .req_valid(req_valid), .req_vec(req_vec), .take(take_w),
    .pend(pend_w), .due(due_w), .eff_mask(eff_mask_w), .mask_q(mask_q_w)
  );

  msix_msg_arb #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .due(due_w), .pick_addr(pick_addr), .pick_data(pick_data), .msg_ready(msg_ready),
    .pick_vec(pick_vec), .take(take_w),
    .msg_valid(msg_valid), .msg_vec(msg_vec), .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: rtl/msix_vec_ctrl_chk.sv
module msix_vec_ctrl_chk #(
  parameter int NUM_VEC = 6,
  parameter int VEC_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [VEC_W-1:0]   req_vec,
  input logic [NUM_VEC-1:0] vec_used,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [VEC_W-1:0]   msg_vec,
  input logic [63:0]        msg_addr,
  input logic [31:0]        msg_data,
  input logic [NUM_VEC-1:0] pend,
  input logic [NUM_VEC-1:0] eff_mask,
  input logic [NUM_VEC-1:0] mask_q
);
  logic [NUM_VEC-1:0] req_oh;

  always_comb begin
    req_oh = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (req_valid && req_vec == VEC_W'(v)) req_oh[v] = 1'b1;
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vec) && $stable(msg_addr) && $stable(msg_data));

  // R6
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_vec < VEC_W'(NUM_VEC));

  // R5
  masked_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_oh & vec_used & eff_mask) != '0 |=> (pend & $past(req_oh)) != '0);

  // R7
  open_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~eff_mask & pend) != '0 |=> (pend & $past(mask_q & ~eff_mask & pend)) == '0);

  // R10
  unused_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~vec_used & ~$past(vec_used)) == '0);
endmodule

bind msix_vec_ctrl msix_vec_ctrl_chk #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec), .vec_used(vec_used),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vec(msg_vec), .msg_addr(msg_addr),
  .msg_data(msg_data), .pend(pend_w), .eff_mask(eff_mask_w), .mask_q(mask_q_w)
);

// File: tb/msix_vec_ctrl_tb.sv
module msix_vec_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC = 6;
  localparam int VEC_W   = 3;
  localparam int WADDR_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msix_en = 1'b0, mask_all = 1'b0;
  logic [NUM_VEC-1:0] vec_used = '0;
  logic req_valid = 1'b0;
  logic [VEC_W-1:0] req_vec = '0;
  logic msg_valid, msg_ready = 1'b0;
  logic [VEC_W-1:0] msg_vec;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic reg_wr = 1'b0, reg_rd = 1'b0, reg_pba = 1'b0;
  logic [WADDR_W-1:0] reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msix_vec_ctrl #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .WADDR_W(WADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .msix_en(msix_en), .mask_all(mask_all), .vec_used(vec_used),
    .req_valid(req_valid), .req_vec(req_vec), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vec(msg_vec), .msg_addr(msg_addr), .msg_data(msg_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_pba(reg_pba), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  function automatic logic [31:0] lo_of(int v);  return 32'hA000_0000 | (v << 4); endfunction
  function automatic logic [31:0] hi_of(int v);  return 32'h10 + v;               endfunction
  function automatic logic [31:0] dat_of(int v); return 32'hD000 + v;             endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(bit pba, int wa, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_pba = pba; reg_waddr = WADDR_W'(wa); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(bit pba, int wa, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_pba = pba; reg_waddr = WADDR_W'(wa);
    @(negedge clk);
    reg_rd = 1'b0;
    if (reg_rvalid !== 1'b1) begin
      total++; bad++;
      $display("FAIL R2 reg_rvalid actual=%b expected=1", reg_rvalid);
    end
    d = reg_rdata;
  endtask

  task automatic send_req(int v);
    @(negedge clk);
    req_valid = 1'b1; req_vec = VEC_W'(v);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_msg(string req, int v);
    int n = 0;
    while (msg_valid !== 1'b1 && n < 10) begin
      @(negedge clk);
      n++;
    end
    chk(req, {63'b0, msg_valid}, 64'd1);
    chk(req, 64'(msg_vec), 64'(v));
    chk(req, msg_addr, {hi_of(v), lo_of(v)});
    chk(req, 64'(msg_data), 64'(dat_of(v)));
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic expect_quiet(string req, int cycles);
    logic seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk(req, {63'b0, seen}, 64'd0);
  endtask

  task automatic pba_check(string req, logic [31:0] exp);
    logic [31:0] d;
    reg_read(1'b1, 0, d);
    chk(req, 64'(d), 64'(exp));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 msg_valid", {63'b0, msg_valid}, 64'd0);
    reg_read(1'b0, 3, d);      chk("R1 ctrl v0", 64'(d), 64'd1);
    reg_read(1'b0, 4*5+3, d);  chk("R1 ctrl v5", 64'(d), 64'd1);
    reg_read(1'b0, 4*2+0, d);  chk("R1 addr_lo v2", 64'(d), 64'd0);
    reg_read(1'b0, 4*2+2, d);  chk("R1 data v2", 64'(d), 64'd0);
    pba_check("R1 pending", 32'h0);
  endtask

  task automatic t_table;
    logic [31:0] d;
    // program every entry; 64-bit address as two word writes
    for (int v = 0; v < NUM_VEC; v++) begin
      reg_write(1'b0, 4*v+0, lo_of(v));
      reg_write(1'b0, 4*v+1, hi_of(v));
      reg_write(1'b0, 4*v+2, dat_of(v));
      reg_write(1'b0, 4*v+3, 32'h0);
    end
    reg_read(1'b0, 4*5+0, d); chk("R2 addr_lo v5", 64'(d), 64'(lo_of(5)));
    reg_read(1'b0, 4*5+1, d); chk("R2 addr_hi v5", 64'(d), 64'(hi_of(5)));
    reg_read(1'b0, 4*5+2, d); chk("R2 data v5", 64'(d), 64'(dat_of(5)));
    reg_write(1'b0, 4*4+3, 32'hFFFF_FFFF);
    reg_read(1'b0, 4*4+3, d); chk("R2 ctrl bit0 only", 64'(d), 64'd1);
    reg_write(1'b0, 4*4+3, 32'h0);
    reg_read(1'b0, 4*4+3, d); chk("R2 ctrl cleared", 64'(d), 64'd0);
    // R12: beyond the table
    reg_write(1'b0, 4*NUM_VEC, 32'h1234_5678);
    reg_read(1'b0, 4*NUM_VEC, d); chk("R12 beyond table", 64'(d), 64'd0);
    reg_read(1'b0, 0, d); chk("R12 no alias v0", 64'(d), 64'(lo_of(0)));
  endtask

  task automatic t_send;
    send_req(2);
    expect_msg("R4 open send v2", 2);
    send_req(0);
    expect_msg("R4 open send v0", 0);
    expect_quiet("R4 single message", 4);
  endtask

  task automatic t_vec_mask;
    reg_write(1'b0, 4*1+3, 32'h1);
    send_req(1);
    expect_quiet("R5 masked no send", 5);
    pba_check("R5 pending v1", 32'h0000_0002);
    // R3: own mask clear but function masked: no replay
    mask_all = 1'b1;
    reg_write(1'b0, 4*1+3, 32'h0);
    expect_quiet("R3 mask_all still blocks", 4);
    pba_check("R3 still pending", 32'h0000_0002);
    reg_write(1'b0, 4*1+3, 32'h1);
    mask_all = 1'b0;
    expect_quiet("R3 own mask still blocks", 3);
    reg_write(1'b0, 4*1+3, 32'h0);
    expect_msg("R7 replay on unmask", 1);
    pba_check("R7 pending cleared", 32'h0);
  endtask

  task automatic t_ignored;
    send_req(6);
    send_req(7);
    expect_quiet("R6 out of range", 4);
    vec_used[0] = 1'b0;
    send_req(0);
    expect_quiet("R6 unused open", 4);
    mask_all = 1'b1;
    send_req(0);
    send_req(7);
    pba_check("R6 no pending", 32'h0);
    mask_all = 1'b0;
    vec_used[0] = 1'b1;
    expect_quiet("R6 nothing replayed", 4);
  endtask

  task automatic t_function;
    logic [VEC_W-1:0] head;
    logic ok = 1'b1;
    msix_en = 1'b0;
    reg_write(1'b0, 4*2+3, 32'h1);
    send_req(3); send_req(1); send_req(4); send_req(2);
    expect_quiet("R8 disabled holds", 3);
    pba_check("R8 pending set", 32'h0000_001E);
    @(negedge clk);
    msix_en = 1'b1;
    repeat (2) @(negedge clk);
    head = msg_vec;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!msg_valid || msg_vec !== head) ok = 1'b0;
    end
    chk("R11 stalled head stable", {63'b0, ok}, 64'd1);
    expect_msg("R11 order first", 1);
    expect_msg("R11 order second", 3);
    expect_msg("R11 order third", 4);
    expect_quiet("R8 masked vector held", 4);
    pba_check("R8 own-masked pending", 32'h0000_0004);
    reg_write(1'b0, 4*2+3, 32'h0);
    expect_msg("R7 late replay v2", 2);
  endtask

  task automatic t_release;
    mask_all = 1'b1;
    send_req(5);
    pba_check("R10 pending v5", 32'h0000_0020);
    @(negedge clk);
    vec_used[5] = 1'b0;
    @(negedge clk);
    pba_check("R10 cleared on release", 32'h0);
    vec_used[5] = 1'b1;
    mask_all = 1'b0;
    expect_quiet("R10 no late send", 5);
  endtask

  task automatic t_pba;
    logic [31:0] d;
    mask_all = 1'b1;
    send_req(0);
    reg_write(1'b1, 0, 32'h0);
    pba_check("R9 write ignored", 32'h0000_0001);
    reg_write(1'b1, 0, 32'hFFFF_FFFF);
    pba_check("R9 write ignored set", 32'h0000_0001);
    reg_read(1'b1, 1, d); chk("R9 upper word", 64'(d), 64'd0);
    reg_read(1'b1, 2, d); chk("R9 beyond region", 64'(d), 64'd0);
    mask_all = 1'b0;
    expect_msg("R9 pending replay v0", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_table();
    msix_en = 1'b1;
    vec_used = '1;
    @(negedge clk);
    t_send();
    t_vec_mask();
    t_ignored();
    t_function();
    t_release();
    t_pba();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule